// File: doc/BRIEF.md
# Immediate Codec Command Port

This block gives software a way to send one codec command and collect its reply without setting up any command or response rings. Software places a 32-bit command word in the command register and starts the exchange by writing 1 to the busy bit of the status register. The block then presents the word on its link-side transmit port for a single cycle. It watches the receive port for a reply from the codec whose address is in bits 31:28 of the command.

When the matching reply arrives, the block captures it in the response register. In that same cycle it drops busy and raises valid. Software clears valid by writing 1 to it, normally before it starts the next command. If the codec stays silent for a set number of link frames, the block gives up. In that case busy drops, valid stays low and a sticky timeout flag is raised.

Top module: `imm_cmd_port`

## Requirements
- R1: After reset the command word, the response word, the status word and the transmit strobe are all zero.
- R2: A register write with select 0 loads the command word when busy is 0. The same write while busy is 1 leaves the command word unchanged.
- R3: A status write (select 1) with bit 0 set while busy is 0 sets busy. On the next clock edge it produces a transmit strobe exactly one cycle wide, carrying the command word.
- R4: While busy, a reply whose address equals command bits 31:28 is captured into the response word. In the same edge busy (status bit 0) clears and valid (status bit 1) sets.
- R5: A reply with another address, or any reply while busy is 0, changes neither the response word nor the status.
- R6: Valid is write-1-to-clear through status bit 1. A status write with bit 1 at 0 leaves it set.
- R7: While busy, once TIMEOUT_FRAMES frame ticks have passed with no matching reply, busy clears, valid stays 0 and the timeout flag (status bit 2) sets. The flag stays set until a status write with bit 2 at 1.
- R8: A matching reply in the same cycle as the expiring frame tick counts as a reply, and no timeout is flagged.
- R9: Status bits 15:3 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Write target: 0 command, 1 status |
| reg_wdata | input | 32 | Write data |
| cmd_word | output | 32 | Command register contents |
| rsp_word | output | 32 | Response register contents |
| status_word | output | 16 | Bit 0 busy, bit 1 valid, bit 2 timeout |
| tx_valid | output | 1 | One-cycle transmit strobe |
| tx_word | output | 32 | Word being transmitted |
| frame_tick | input | 1 | One pulse per link frame |
| rx_valid | input | 1 | Reply present on the receive port |
| rx_addr | input | 4 | Codec address of the reply |
| rx_word | input | 32 | Reply data |

## Verification
A wrong busy bit shows up at the status port on the edge after the offending write or reply. It appears either as a second transmit strobe or as a command word that moves while an exchange is in flight. A miscounted frame counter shows as a timeout flag that arrives one tick early or late against the bench's own tick count. A wrong address compare shows up as a foreign reply landing in the response word on the very next sample.

// File: rtl/imm_cmd_port.sv
module imm_cmd_port #(
  parameter int TIMEOUT_FRAMES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] cmd_word,
  output logic [31:0] rsp_word,
  output logic [15:0] status_word,
  output logic        tx_valid,
  output logic [31:0] tx_word,
  input  logic        frame_tick,
  input  logic        rx_valid,
  input  logic [3:0]  rx_addr,
  input  logic [31:0] rx_word
);
  localparam int CW = $clog2(TIMEOUT_FRAMES + 1);

  logic          busy, valid, tmo;
  logic [CW-1:0] frames;

  wire wr_cmd = reg_wr && reg_sel == 2'd0;
  wire wr_sts = reg_wr && reg_sel == 2'd1;
  wire start  = wr_sts && reg_wdata[0] && !busy;
  wire hit    = busy && rx_valid && rx_addr == cmd_word[31:28];
  wire expire = busy && !hit && frame_tick && frames == CW'(TIMEOUT_FRAMES - 1);

  assign status_word = {13'd0, tmo, valid, busy};
  assign tx_word     = cmd_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_word <= '0;
      rsp_word <= '0;
      busy     <= 1'b0;
      valid    <= 1'b0;
      tmo      <= 1'b0;
      frames   <= '0;
      tx_valid <= 1'b0;
    end else begin
      tx_valid <= start;
      if (wr_cmd && !busy) cmd_word <= reg_wdata;
      if (hit) rsp_word <= rx_word;

      if (start)              busy <= 1'b1;
      else if (hit || expire) busy <= 1'b0;

      if (start)                   frames <= '0;
      else if (busy && frame_tick) frames <= frames + 1'b1;

      if (hit)                          valid <= 1'b1;
      else if (wr_sts && reg_wdata[1])  valid <= 1'b0;

      if (expire)                       tmo <= 1'b1;
      else if (wr_sts && reg_wdata[2])  tmo <= 1'b0;
    end
  end

  AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_cmd) |=> $stable(cmd_word)); // R2
  AST_TX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> !tx_valid); // R3
  AST_TX_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> busy); // R3
  AST_HIT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (!busy && valid && rsp_word == $past(rx_word))); // R4
  AST_IDLE_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(rsp_word)); // R5
  AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo && !(wr_sts && reg_wdata[2])) |=> tmo); // R7
  AST_TMO_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo) |-> (!busy && !$rose(valid))); // R7
endmodule

// File: tb/imm_cmd_port_bench.sv
module imm_cmd_port_bench;
  localparam int TO = 4;
  logic        clk = 0, rst_n = 0, reg_wr = 0, frame_tick = 0, rx_valid = 0;
  logic [1:0]  reg_sel = 0;
  logic [31:0] reg_wdata = 0, rx_word = 0;
  logic [3:0]  rx_addr = 0;
  logic [31:0] cmd_word, rsp_word, tx_word;
  logic [15:0] status_word;
  logic        tx_valid;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  imm_cmd_port #(.TIMEOUT_FRAMES(TO)) u_imm_cmd_port (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .cmd_word(cmd_word), .rsp_word(rsp_word),
    .status_word(status_word), .tx_valid(tx_valid), .tx_word(tx_word),
    .frame_tick(frame_tick), .rx_valid(rx_valid), .rx_addr(rx_addr),
    .rx_word(rx_word));

  function automatic logic [15:0] sts(input bit b, input bit v, input bit t);
    return {13'd0, t, v, b};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    reg_wr = 1; reg_sel = sel; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic step(input bit tick, input bit rv, input logic [3:0] a, input logic [31:0] d);
    frame_tick = tick; rx_valid = rv; rx_addr = a; rx_word = d;
    @(posedge clk); @(negedge clk);
    frame_tick = 0; rx_valid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp_rsp;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1
    chk("R1 status", status_word, 0); chk("R1 cmd", cmd_word, 0);
    chk("R1 rsp", rsp_word, 0); chk("R1 tx", tx_valid, 0);
    rst_n = 1; @(negedge clk);
    exp_rsp = 0;

    // R5: reply while idle ignored
    step(0, 1, 4'h0, 32'hDEADBEEF);
    chk("R5 idle rsp", rsp_word, 0); chk("R5 idle status", status_word, sts(0,0,0));

    for (int i = 0; i < 60; i++) begin
      logic [31:0] c;
      int nf;
      bit do_rsp;
      c = $urandom;
      wr(0, c); chk("R2 cmd load", cmd_word, c);
      wr(1, 32'h6);
      wr(1, 32'h1);
      chk("R3 busy", status_word, sts(1,0,0));
      chk("R3 tx strobe", tx_valid, 1); chk("R3 tx word", tx_word, c);
      step(0, 0, 0, 0);
      chk("R3 tx single", tx_valid, 0);
      wr(0, ~c); chk("R2 write ignored", cmd_word, c);
      nf = int'($urandom % (TO - 1));
      for (int k = 0; k < nf; k++) begin
        step(1, 1, c[31:28] ^ 4'h5, $urandom);
        chk("R5 foreign reply", rsp_word, exp_rsp);
      end
      chk("R5 still busy", status_word, sts(1,0,0));
      do_rsp = $urandom % 2;
      if (do_rsp) begin
        logic [31:0] r;
        r = $urandom;
        step(0, 1, c[31:28], r);
        exp_rsp = r;
        chk("R4 rsp", rsp_word, exp_rsp); chk("R4 status", status_word, sts(0,1,0));
        wr(1, 32'h0); chk("R6 write0 keeps valid", status_word, sts(0,1,0));
        wr(1, 32'h2); chk("R6 w1c", status_word, sts(0,0,0));
      end else begin
        for (int k = nf; k < TO - 1; k++) step(1, 0, 0, 0);
        chk("R7 not yet", status_word, sts(1,0,0));
        step(1, 0, 0, 0);
        chk("R7 timeout", status_word, sts(0,0,1)); chk("R7 rsp held", rsp_word, exp_rsp);
        step(0, 1, c[31:28], 32'h1);
        chk("R5 late reply", rsp_word, exp_rsp);
        wr(1, 32'h2); chk("R7 sticky", status_word, sts(0,0,1));
        wr(1, 32'h4); chk("R7 clear", status_word, sts(0,0,0));
      end
    end

    // R8: reply with expiring tick
    wr(0, 32'hA0001234); wr(1, 32'h1);
    for (int k = 0; k < TO - 1; k++) step(1, 0, 0, 0);
    step(1, 1, 4'hA, 32'h55AA55AA);
    chk("R8 status", status_word, sts(0,1,0)); chk("R8 rsp", rsp_word, 32'h55AA55AA);

    // R9: all-ones status write
    wr(1, 32'hFFFFFFFF);
    chk("R9 high bits", status_word & 16'hFFF8, 0);
    chk("R9 busy set", status_word, sts(1,0,0));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule